// File: doc/BRIEF.md
# Two-Wire Register Target with Strap Address

This block is the two-wire serial target that sits in front of a 64-entry byte register file. It filters the clock and data lines and detects START, repeated START and STOP. It matches the bus address against a fixed five-bit zero prefix followed by two strap inputs, and it keeps a word pointer into the register file. Incoming data bytes become one-cycle write strobes. Read bytes are taken from the register file through a read address port and are shifted out by pulling the data line low through an open-drain enable.

The host writes by sending the target address with the direction bit clear, then a word address, then any number of data bytes. The pointer advances after each data byte. The host reads in one of two ways. It can send a repeated START after the word address and then the target address with the direction bit set. It can also open a fresh transaction with the read address, and reading then continues from the last pointer value. The pointer advances after every byte sent. The host ends a read by not acknowledging the last byte. A data byte of 0x96 written to word 0x3C or 0x3D is not stored: it fires a preset pulse or a calibrate pulse instead.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the target drives no data-line low (sda_oe = 0) and raises no write strobe or command pulse.
- R2: The target acknowledges only the address byte {00000, addr_sel[1], addr_sel[0], rw}, where rw = 0 means write and rw = 1 means read. It acknowledges by driving the data line low during the ninth clock pulse. For any other address it never drives the line and produces no strobe until the next START.
- R3: In a write transaction, the byte after the address is the word address (its low 6 bits are used). Each following data byte gives one single-cycle wr_en pulse, with wr_addr equal to the pointer and wr_data equal to the byte, sent MSB first. Each data byte is acknowledged.
- R4: The pointer increments after every data byte written and wraps from 63 to 0.
- R5: After a repeated START and the read address, the target returns, MSB first, the register byte at the word address most recently set.
- R6: During a read the pointer increments after every byte sent. When the host acknowledges (data line low in the ninth pulse), the next byte follows. When the host does not acknowledge, the target releases the data line and stays silent until STOP or START.
- R7: A read opened by a fresh START, with no word address, continues from the pointer value left by the previous transaction.
- R8: A data byte of 0x96 at pointer 0x3C gives one cmd_preset pulse, and at 0x3D one cmd_calib pulse. In both cases there is no wr_en and the pointer still increments. Any other byte at those addresses is written normally.
- R9: Pulses on either line shorter than FILT_LEN clock cycles (default 10, which is 50 ns at 200 MHz) are ignored. In particular, a short data pulse while the clock is high is not taken as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| addr_sel | input | 2 | Strap bits forming the low two address bits |
| rd_data | input | 8 | Register file byte at rd_addr (combinational read) |
| sda_oe | output | 1 | 1 = pull the data line low |
| rd_addr | output | 6 | Current word pointer, used as read address |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_addr | output | 6 | Write address, valid with wr_en |
| wr_data | output | 8 | Write data, valid with wr_en |
| cmd_preset | output | 1 | Single-cycle preset command pulse |
| cmd_calib | output | 1 | Single-cycle calibrate command pulse |

## Verification
A wrong pointer shows up at once as a wrong wr_addr on the next strobe, or as a wrong byte returned in the next read. This is checked over a page that wraps and over a read that resumes in a new transaction. A broken bit counter or state sequence moves the acknowledge slot, so the host sees a missing or early acknowledge on the very next byte. A broken command decode shows up as a stray wr_en or a missing pulse within a clock of the eighth data bit. The strobe monitor compares every cycle against the queue of expected effects, so a strobe that should not happen is reported in the cycle it appears.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the two-wire register target.
// Assumes a register file of at most 256 bytes addressed by the word pointer.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_DEV,     // receiving target address byte
        ST_WADR,    // receiving word address byte
        ST_WDAT,    // receiving data bytes
        ST_ACK,     // target drives acknowledge
        ST_RDAT,    // target shifts a byte out
        ST_RACK,    // host acknowledge slot
        ST_WAIT     // silent until START or STOP
    } tgt_state_e;

    localparam logic [7:0] CMD_KEY    = 8'h96;
    localparam logic [7:0] PRESET_ADR = 8'h3C;
    localparam logic [7:0] CALIB_ADR  = 8'h3D;
    localparam int unsigned BYTE_W    = 8;
endpackage

// File: rtl/i2c_deglitch.sv
// Two-flop synchronizer followed by a stability filter. The output follows the
// input only after the input has held a new level for FILT_LEN clock cycles.
// Assumes the idle line level is high.
module i2c_deglitch #(
    parameter int unsigned FILT_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Synchronize and accept a new level only once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            line_o <= 1'b1;
            cnt    <= '0;
        end else begin
            s1 <= line_i;
            s2 <= s1;
            if (s2 == line_o) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                line_o <= s2;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9
    filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> (line_o == $past(s2)) && ($past(cnt) == CW'(FILT_LEN - 1)));
endmodule

// File: rtl/i2c_bus_cond.sv
// Turns filtered clock and data levels into single-cycle clock edges and
// START / STOP events. Assumes both inputs come through equal filter delays.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edges and bus conditions from current and previous levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte-level protocol engine: address match, word pointer, write strobes,
// command decode and read shifting. Samples data on clock rise and changes
// its own drive on clock fall. rd_data must be valid in the cycle rd_addr shows.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                sda_s,
    input  logic [1:0]          addr_sel,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                sda_oe,
    output logic [ADDR_W-1:0]   ptr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                cmd_preset,
    output logic                cmd_calib
);
    tgt_state_e        state, after_ack;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rxd, txd;
    logic              host_nack;
    logic              addr_hit, is_key;

    // Address and command key comparisons on the received byte.
    always_comb begin
        addr_hit = (rxd[7:1] == {5'b00000, addr_sel});
        is_key   = (rxd == CMD_KEY);
    end

    // Protocol sequencing, pointer and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            bitcnt     <= '0;
            rxd        <= '0;
            txd        <= '0;
            host_nack  <= 1'b0;
            sda_oe     <= 1'b0;
            ptr        <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            cmd_preset <= 1'b0;
            cmd_calib  <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            cmd_preset <= 1'b0;
            cmd_calib  <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (scl_rise) begin
                            rxd    <= {rxd[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) begin
                                if (addr_hit) begin
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                    after_ack <= rxd[0] ? ST_RDAT : ST_WADR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe    <= 1'b1;
                                state     <= ST_ACK;
                                after_ack <= ST_WDAT;
                                if (state == ST_WADR) begin
                                    ptr <= rxd[ADDR_W-1:0];
                                end else begin
                                    ptr <= ptr + 1'b1;
                                    if (is_key && ptr == ADDR_W'(PRESET_ADR))
                                        cmd_preset <= 1'b1;
                                    else if (is_key && ptr == ADDR_W'(CALIB_ADR))
                                        cmd_calib <= 1'b1;
                                    else begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= rxd;
                                    end
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= after_ack;
                            if (after_ack == ST_RDAT) begin
                                txd    <= {rd_data[6:0], 1'b0};
                                sda_oe <= ~rd_data[7];
                                bitcnt <= 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~txd[7];
                                txd    <= {txd[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_nack <= sda_s;
                            ptr       <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            if (!host_nack) begin
                                txd    <= {rd_data[6:0], 1'b0};
                                sda_oe <= ~rd_data[7];
                                bitcnt <= 4'd1;
                                state  <= ST_RDAT;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == wr_addr + 1'b1));

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: rtl/i2c_reg_target.sv
// Top of the two-wire register target: line filters, bus condition detector
// and protocol engine. The register file itself lives outside this block.
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned FILT_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              cmd_preset,
    output logic              cmd_calib
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw_l, filt_l;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_l = {sda_i, scl_i};

    // One filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_l[g]),
            .line_o (filt_l[g])
        );
    end

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_l[0]),
        .sda_f     (filt_l[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_s      (filt_l[1]),
        .addr_sel   (addr_sel),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .ptr        (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd_preset (cmd_preset),
        .cmd_calib  (cmd_calib)
    );

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, cmd_preset, cmd_calib}));
endmodule

// File: tb/tb_i2c_reg_target.sv
// Bench: behavioural host, register file model, expected-effect queue checked
// every clock against the strobes, and read data checked against a model.
module tb_i2c_reg_target;
    localparam int Q = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] sel = 2'b10;
    logic [7:0] rd_data;
    logic       sda_oe, wr_en, cmd_preset, cmd_calib;
    logic [5:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    wire        sda_line = sda_h & ~sda_oe;

    int errors = 0;
    int checks = 0;

    logic [7:0]  regs [64];
    logic [7:0]  exp_mem [64];
    logic [17:0] exp_q [$];
    int          mptr = 0;

    always #2.5 clk = ~clk;

    i2c_reg_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel(sel), .rd_data(rd_data), .sda_oe(sda_oe), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_preset(cmd_preset), .cmd_calib(cmd_calib)
    );

    initial for (int i = 0; i < 64; i++) begin
        regs[i] = 8'((i * 37 + 5) & 255);
        exp_mem[i] = 8'((i * 37 + 5) & 255);
    end

    always @(posedge clk) if (wr_en) regs[wr_addr] <= wr_data;
    assign rd_data = regs[rd_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Compare every strobe with the expected effect queue (R3 R4 R8).
    always @(negedge clk) begin
        if (rst_n && (wr_en || cmd_preset || cmd_calib)) begin
            logic [17:0] got;
            got = {wr_en ? 2'd0 : (cmd_preset ? 2'd1 : 2'd2),
                   wr_en ? {2'b00, wr_addr} : 8'h00, wr_en ? wr_data : 8'h00};
            if (exp_q.size() == 0) chk(0, "R2_R3_R8 unexpected strobe", int'(got), 0);
            else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(got == e, "R3_R4_R8 strobe", int'(got), int'(e));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_eff(input logic [1:0] k, input logic [5:0] a, input logic [7:0] d);
        exp_q.push_back({k, 2'b00, a, d});
        if (k == 2'd0) exp_mem[a] = d;
    endtask

    task automatic bit_w(input logic b);
        sda_h = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bit_w_glitch(input logic b);
        sda_h = b; tick(Q); scl = 1'b1; tick(20);
        sda_h = ~b; tick(4); sda_h = b; tick(20);
        scl = 1'b0; tick(4); scl = 1'b1; tick(2 * Q - 48);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(2 * Q);
        chk(exp_q.size() == 0, "R2_R3 pending effects after STOP", exp_q.size(), 0);
    endtask

    task automatic send(input logic [7:0] d, input bit exp_ack, input bit glitch, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) begin
            if (glitch) bit_w_glitch(d[i]); else bit_w(d[i]);
        end
        bit_r(a);
        chk((!a) == exp_ack, req, int'(!a), int'(exp_ack));
    endtask

    task automatic recv(input bit host_ack, input string req);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        chk(d == exp_mem[mptr], req, d, exp_mem[mptr]);
        mptr = (mptr + 1) & 63;
        bit_w(!host_ack);
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {5'b00000, sel, rw};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        tick(5);
        chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(20);
        chk(sda_oe == 1'b0 && !wr_en && !cmd_preset && !cmd_calib, "R1 idle outputs",
            {sda_oe, wr_en, cmd_preset, cmd_calib}, 0);

        // R3 single write
        bus_start(); send(dev(0), 1, 0, "R2 ack own write address");
        send(8'h05, 1, 0, "R3 ack word address");
        expect_eff(0, 6'h05, 8'h3A); send(8'h3A, 1, 0, "R3 ack data");
        bus_stop(); mptr = 6;

        // R4 page write with wrap
        bus_start(); send(dev(0), 1, 0, "R2 ack"); send(8'h3E, 1, 0, "R4 word address");
        expect_eff(0, 6'h3E, 8'h11); send(8'h11, 1, 0, "R4 data0");
        expect_eff(0, 6'h3F, 8'h22); send(8'h22, 1, 0, "R4 data1");
        expect_eff(0, 6'h00, 8'h33); send(8'h33, 1, 0, "R4 wrap data2");
        expect_eff(0, 6'h01, 8'h44); send(8'h44, 1, 0, "R4 data3");
        bus_stop();

        // R5 random read via repeated START, R6 sequential with NACK end
        bus_start(); send(dev(0), 1, 0, "R5 ack"); send(8'h3E, 1, 0, "R5 word address");
        mptr = 6'h3E;
        bus_start(); send(dev(1), 1, 0, "R5 ack read address");
        recv(1, "R5 first read byte");
        recv(1, "R6 second read byte");
        recv(0, "R6 wrapped third byte");
        tick(Q);
        chk(sda_line == 1'b1 && sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        bus_stop();

        // R7 fresh read continues from pointer
        bus_start(); send(dev(1), 1, 0, "R7 ack fresh read");
        recv(0, "R7 byte at resumed pointer");
        bus_stop();

        // R8 commands
        bus_start(); send(dev(0), 1, 0, "R8 ack"); send(8'h3C, 1, 0, "R8 word address");
        expect_eff(1, 6'h00, 8'h00); send(8'h96, 1, 0, "R8 preset key");
        expect_eff(2, 6'h00, 8'h00); send(8'h96, 1, 0, "R8 calib key");
        expect_eff(0, 6'h3E, 8'h55); send(8'h55, 1, 0, "R8 normal after keys");
        bus_stop();
        bus_start(); send(dev(0), 1, 0, "R8 ack"); send(8'h3C, 1, 0, "R8 word address");
        mptr = 6'h3C;
        bus_start(); send(dev(1), 1, 0, "R8 ack read");
        recv(1, "R8 preset key not stored");
        recv(0, "R8 calib key not stored");
        bus_stop();
        bus_start(); send(dev(0), 1, 0, "R8 ack"); send(8'h3C, 1, 0, "R8 word address");
        expect_eff(0, 6'h3C, 8'h12); send(8'h12, 1, 0, "R8 non-key stored");
        bus_stop();

        // R2 foreign address ignored
        bus_start(); send({5'b00000, 2'b01, 1'b0}, 0, 0, "R2 no ack foreign address");
        send(8'h07, 0, 0, "R2 no ack after mismatch");
        send(8'hAA, 0, 0, "R2 no ack after mismatch");
        bus_stop();
        bus_start(); send(8'h40 | dev(0), 0, 0, "R2 no ack upper prefix bit");
        bus_stop();

        // R2 other strap value
        sel = 2'b01;
        bus_start(); send(dev(0), 1, 0, "R2 ack new strap"); send(8'h20, 1, 0, "R2 word address");
        expect_eff(0, 6'h20, 8'h77); send(8'h77, 1, 0, "R2 data");
        bus_stop();

        // R9 glitches on both lines during a data byte
        bus_start(); send(dev(0), 1, 0, "R9 ack"); send(8'h21, 1, 0, "R9 word address");
        expect_eff(0, 6'h21, 8'hC5); send(8'hC5, 1, 1, "R9 glitched data");
        expect_eff(0, 6'h22, 8'h3B); send(8'h3B, 1, 0, "R9 following data");
        bus_stop();
        bus_start(); send(dev(0), 1, 0, "R9 ack"); send(8'h20, 1, 0, "R9 word address");
        mptr = 6'h20;
        bus_start(); send(dev(1), 1, 0, "R9 ack read");
        recv(1, "R2 readback strap write");
        recv(1, "R9 readback glitched byte");
        recv(0, "R9 readback following byte");
        bus_stop();

        tick(20);
        finish_run();
    end
endmodule